// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounder

This unit rounds a wide, unpacked floating-point significand to its final precision. The two lowest bits of the incoming significand hold the guard bit (upper) and the round bit (lower). A separate sticky flag stands for all bits already shifted away below them. The unit drops the guard and round bits and decides, from a 2-bit mode, the sign and those three low-order indicators, whether to add one at the new least significant bit. It also flags whether the value was inexact.

The increment ripples across the whole significand. An all-ones significand can therefore carry into one extra top bit. That bit is returned to the caller, which renormalises the value and adjusts the exponent. The unit does not handle the exponent, packing or exceptions. All three results are registered, so they appear one clock after the inputs are presented.

Top module: `rnd_unit`

## Requirements
- R1: When guard, round and sticky are all zero, the result equals the input shifted right by two, and both `rnd_up_o` and `inexact_o` are 0.
- R2: `inexact_o` is 1 exactly when at least one of guard (`mant_i[1]`), round (`mant_i[0]`) or `sticky_i` is 1, in every mode.
- R3: Mode 2'b00 (nearest) adds one only when guard is 1 and at least one of round, sticky or the shifted LSB (`mant_i[2]`) is 1. A tie therefore rounds to the even value.
- R4: Mode 2'b01 (toward zero) never adds one.
- R5: Mode 2'b10 (toward minus infinity) adds one exactly when the value is inexact and `sign_i` is 1.
- R6: Mode 2'b11 (toward plus infinity) adds one exactly when the value is inexact and `sign_i` is 0.
- R7: The increment carries across the full shifted width. An all-ones shifted value that is rounded up gives `res_mant_o` with only its top bit set.
- R8: `rnd_up_o` is 1 exactly when `res_mant_o` equals the shifted input plus one. Otherwise `res_mant_o` equals the shifted input, with the top bit 0.
- R9: The results appear on the clock edge after the inputs are presented, and they stay stable until the next edge. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mant_i | input | MANT_W | Significand; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits below the round bit |
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mode_i | input | 2 | 00 nearest, 01 toward zero, 10 toward minus infinity, 11 toward plus infinity |
| res_mant_o | output | MANT_W-1 | Shifted significand after rounding; top bit is the carry-out |
| rnd_up_o | output | 1 | One was added |
| inexact_o | output | 1 | Guard, round or sticky was set |

## Verification
In a single cycle, the nearest-mode tie-breaking decision and the full-width carry can both occur. This happens when the shifted value is all ones, which makes it odd, while only the guard bit is set. The bench presents that pattern and expects the tie to resolve upward. The result must then show only the top carry bit set, together with `rnd_up_o` and `inexact_o`. Companion cases check the same all-ones value under toward-zero and with guard clear, where the carry must not appear.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_ZERO    = 2'b01,
        RM_NEG     = 2'b10,
        RM_POS     = 2'b11
    } rnd_mode_e;

endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
    import rnd_pkg::*;
(
    input  logic      guard_i,
    input  logic      round_i,
    input  logic      sticky_i,
    input  logic      lsb_i,
    input  logic      sign_i,
    input  rnd_mode_e mode_i,
    output logic      bump_o,
    output logic      inexact_o
);

    logic lost;

    assign lost      = guard_i | round_i | sticky_i;
    assign inexact_o = lost;

    always_comb begin
        bump_o = 1'b0;
        unique case (mode_i)
            RM_NEAREST: bump_o = guard_i & (round_i | sticky_i | lsb_i);
            RM_ZERO:    bump_o = 1'b0;
            RM_NEG:     bump_o = lost & sign_i;
            RM_POS:     bump_o = lost & ~sign_i;
            default:    bump_o = 1'b0;
        endcase
    end

    always_comb begin
        if (!lost) begin
            AST_EXACT_KEEPS: assert (!bump_o); // R1
        end
    end

endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
    parameter int W     = 64,
    parameter int CHUNK = 16
) (
    input  logic [W-1:0] val_i,
    input  logic         inc_i,
    output logic [W:0]   sum_o
);

    localparam int NCH = W / CHUNK + 1;

    logic [W:0]     ext;
    logic [NCH-1:0] cin;

    assign ext = {1'b0, val_i};

    for (genvar i = 0; i < NCH; i++) begin : g_chunk
        localparam int LO = i * CHUNK;
        localparam int HI = (LO + CHUNK - 1 > W) ? W : LO + CHUNK - 1;
        localparam int CW = HI - LO + 1;

        if (i == 0) begin : g_first
            assign cin[i] = inc_i;
        end else begin : g_next
            localparam int PLO = (i - 1) * CHUNK;
            localparam int PHI = PLO + CHUNK - 1;
            assign cin[i] = cin[i-1] & (&ext[PHI:PLO]);
        end

        assign sum_o[HI:LO] = ext[HI:LO] + CW'(cin[i]);
    end

endmodule

// File: rtl/rnd_unit.sv
module rnd_unit
    import rnd_pkg::*;
#(
    parameter int MANT_W  = 66,
    parameter int CHUNK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MANT_W-1:0] mant_i,
    input  logic              sticky_i,
    input  logic              sign_i,
    input  logic [1:0]        mode_i,
    output logic [MANT_W-2:0] res_mant_o,
    output logic              rnd_up_o,
    output logic              inexact_o
);

    localparam int FRAC_W = MANT_W - 2;
    localparam int RES_W  = MANT_W - 1;

    logic [FRAC_W-1:0] shifted;
    logic              bump;
    logic              inexact_d;
    logic [RES_W-1:0]  sum;
    rnd_mode_e         mode;
    logic              primed_q;

    assign shifted = mant_i[MANT_W-1:2];
    assign mode    = rnd_mode_e'(mode_i);

    rnd_decide u_decide (
        .guard_i  (mant_i[1]),
        .round_i  (mant_i[0]),
        .sticky_i (sticky_i),
        .lsb_i    (mant_i[2]),
        .sign_i   (sign_i),
        .mode_i   (mode),
        .bump_o   (bump),
        .inexact_o(inexact_d)
    );

    rnd_incr #(
        .W    (FRAC_W),
        .CHUNK(CHUNK_W)
    ) u_incr (
        .val_i(shifted),
        .inc_i(bump),
        .sum_o(sum)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_mant_o <= '0;
            rnd_up_o   <= 1'b0;
            inexact_o  <= 1'b0;
            primed_q   <= 1'b0;
        end else begin
            res_mant_o <= sum;
            rnd_up_o   <= bump;
            inexact_o  <= inexact_d;
            primed_q   <= 1'b1;
        end
    end

    AST_EXACT_NO_BUMP: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(mant_i[1:0]) == 2'b00 && !$past(sticky_i)) |-> (!rnd_up_o && !inexact_o)); // R1
    AST_INEXACT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (inexact_o == ($past(mant_i[1:0]) != 2'b00 || $past(sticky_i)))); // R2
    AST_ZERO_NEVER_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(mode_i) == 2'b01) |-> !rnd_up_o); // R4
    AST_NEG_DIRECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(mode_i) == 2'b10) |-> (rnd_up_o == ($past(sign_i) && inexact_o))); // R5
    AST_POS_DIRECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(mode_i) == 2'b11) |-> (rnd_up_o == (!$past(sign_i) && inexact_o))); // R6
    AST_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        primed_q |-> (res_mant_o == ({1'b0, $past(mant_i[MANT_W-1:2])} + RES_W'(rnd_up_o)))); // R8

endmodule

// File: tb/tb_rnd_unit.sv
module tb_rnd_unit;

    localparam int MW = 66;
    localparam int FW = MW - 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [MW-1:0] mant_i = '0;
    logic          sticky_i = 1'b0;
    logic          sign_i = 1'b0;
    logic [1:0]    mode_i = 2'b00;
    logic [MW-2:0] res_mant_o;
    logic          rnd_up_o;
    logic          inexact_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rnd_unit #(.MANT_W(MW), .CHUNK_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .mant_i(mant_i), .sticky_i(sticky_i),
        .sign_i(sign_i), .mode_i(mode_i), .res_mant_o(res_mant_o),
        .rnd_up_o(rnd_up_o), .inexact_o(inexact_o)
    );

    task automatic check(input string req, input logic [MW-2:0] got_m, input logic [MW-2:0] exp_m,
                         input logic got_u, input logic exp_u, input logic got_x, input logic exp_x);
        checks++;
        if (got_m !== exp_m || got_u !== exp_u || got_x !== exp_x) begin
            errors++;
            $display("FAIL %s: got res=%h up=%b inx=%b expected res=%h up=%b inx=%b",
                     req, got_m, got_u, got_x, exp_m, exp_u, exp_x);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
    task automatic run(input string req, input logic [FW-1:0] frac, input logic g, input logic r,
                       input logic s, input logic sg, input logic [1:0] md,
                       input logic [MW-2:0] exp_m, input logic exp_u, input logic exp_x);
        @(negedge clk);
        mant_i = {frac, g, r}; sticky_i = s; sign_i = sg; mode_i = md;
        @(posedge clk);
        @(negedge clk);
        check(req, res_mant_o, exp_m, rnd_up_o, exp_u, inexact_o, exp_x);
    endtask

    function automatic logic [MW-2:0] plus1(input logic [FW-1:0] f);
        return {1'b0, f} + 1'b1;
    endfunction

    task automatic t_reset;
        mant_i = {FW'(64'hFFFF), 2'b11}; sticky_i = 1'b1;
        #1;
        check("R9 reset", res_mant_o, '0, rnd_up_o, 1'b0, inexact_o, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_exact;
        logic [FW-1:0] f = 64'h1234_5678_9ABC_DEF1;
        for (int m = 0; m < 4; m++)
            run("R1 exact", f, 0, 0, 0, m[0], 2'(m), {1'b0, f}, 1'b0, 1'b0);
    endtask

    task automatic t_nearest;
        logic [FW-1:0] ev = 64'h0000_0000_0000_1000;
        logic [FW-1:0] od = 64'h0000_0000_0000_1001;
        run("R3 tie even stays", ev, 1, 0, 0, 0, 2'b00, {1'b0, ev}, 1'b0, 1'b1);
        run("R3 tie odd bumps", od, 1, 0, 0, 0, 2'b00, plus1(od), 1'b1, 1'b1);
        run("R3 guard+round", ev, 1, 1, 0, 1, 2'b00, plus1(ev), 1'b1, 1'b1);
        run("R3 guard+sticky", ev, 1, 0, 1, 0, 2'b00, plus1(ev), 1'b1, 1'b1);
        run("R3 below half", od, 0, 1, 1, 0, 2'b00, {1'b0, od}, 1'b0, 1'b1);
        run("R2 sticky only", ev, 0, 0, 1, 0, 2'b00, {1'b0, ev}, 1'b0, 1'b1);
    endtask

    task automatic t_zero;
        logic [FW-1:0] f = 64'h8000_0000_0000_0003;
        run("R4 zero pos", f, 1, 1, 1, 0, 2'b01, {1'b0, f}, 1'b0, 1'b1);
        run("R4 zero neg", f, 1, 0, 0, 1, 2'b01, {1'b0, f}, 1'b0, 1'b1);
    endtask

    task automatic t_directed;
        logic [FW-1:0] f = 64'hC000_0000_0000_0010;
        run("R5 minf neg", f, 0, 1, 0, 1, 2'b10, plus1(f), 1'b1, 1'b1);
        run("R5 minf pos", f, 0, 1, 0, 0, 2'b10, {1'b0, f}, 1'b0, 1'b1);
        run("R6 pinf pos", f, 0, 0, 1, 0, 2'b11, plus1(f), 1'b1, 1'b1);
        run("R6 pinf neg", f, 1, 0, 0, 1, 2'b11, {1'b0, f}, 1'b0, 1'b1);
        run("R5 minf exact", f, 0, 0, 0, 1, 2'b10, {1'b0, f}, 1'b0, 1'b0);
    endtask

    task automatic t_carry;
        logic [FW-1:0] ones = '1;
        logic [FW-1:0] mid = 64'h0000_FFFF_FFFF_FFFF;
        run("R7 all-ones tie", ones, 1, 0, 0, 0, 2'b00, {1'b1, {FW{1'b0}}}, 1'b1, 1'b1);
        run("R7 all-ones zero", ones, 1, 1, 1, 0, 2'b01, {1'b0, ones}, 1'b0, 1'b1);
        run("R7 all-ones below", ones, 0, 1, 1, 0, 2'b00, {1'b0, ones}, 1'b0, 1'b1);
        run("R8 chunk carry", mid, 0, 0, 1, 0, 2'b11, 65'h0_0001_0000_0000_0000, 1'b1, 1'b1);
    endtask

    task automatic t_latency;
        logic [FW-1:0] a = 64'h0000_0000_0000_0005;
        logic [FW-1:0] b = 64'h0000_0000_0000_0A00;
        run("R9 first", a, 1, 1, 0, 0, 2'b00, plus1(a), 1'b1, 1'b1);
        @(negedge clk);
        mant_i = {b, 2'b00}; sticky_i = 1'b0; mode_i = 2'b01;
        #1;
        check("R9 held before edge", res_mant_o, plus1(a), rnd_up_o, 1'b1, inexact_o, 1'b1);
        @(posedge clk);
        @(negedge clk);
        check("R9 after edge", res_mant_o, {1'b0, b}, rnd_up_o, 1'b0, inexact_o, 1'b0);
    endtask

    initial begin
        t_reset();
        t_exact();
        t_nearest();
        t_zero();
        t_directed();
        t_carry();
        t_latency();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule